// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. It passes the four incoming handshake lines (clear-to-send, data-set-ready, ring indicator, carrier detect) through a synchroniser. It then keeps their current levels together with a sticky record of which lines changed. It drives the request-to-send, data-terminal-ready and two general-purpose outputs.

A byte-wide register port selects either the control byte or the status byte. Read data appears combinationally while the read strobe is high. The side effects of a read take place at the clock edge that ends the access. A single change flag goes to the interrupt logic of the port.

A loopback test mode is available. In this mode a status read shows the control outputs in place of the line levels, and the request-to-send and data-terminal-ready pins keep their last driven state.

Top module: `mdm_ctl_stat`

## Requirements
- R1: The control byte keeps five bits: data-terminal-ready at bit 0, request-to-send at bit 1, general output one at bit 2, general output two at bit 3 and loopback at bit 4. A read of the control byte (select = 0) returns these bits, with bits 7..5 read as zero.
- R2: After reset:
  - the control byte reads 0x08;
  - the status byte (select = 1) reads 0xB0;
  - the change flag is low;
  - the request-to-send and data-terminal-ready pins are low.
- R3: The status byte holds the synchronised line levels in its upper nibble: carrier detect at bit 7, ring at bit 6, data-set-ready at bit 5 and clear-to-send at bit 4. A pin change becomes visible at the third rising edge after it is applied.
- R4: Delta bits record changes. Bit 0 is set by any change of clear-to-send, bit 1 by any change of data-set-ready and bit 3 by any change of carrier detect. Each delta bit stays set until it is cleared by a status read.
- R5: Status bit 2 is set only when the ring level falls from 1 to 0. A rising ring level leaves it unchanged.
- R6: A status read outside loopback returns the byte as it stood before the edge and clears all four delta bits at that edge. A change detected at the same edge as the read is kept after the read.
- R7: In loopback, a status read returns general output two at bit 7, general output one at bit 6, data-terminal-ready at bit 5 and request-to-send at bit 4. The low nibble reads as zero, and the read does not clear the delta bits.
- R8: A control write with bit 4 set leaves the request-to-send and data-terminal-ready pins unchanged. A control write with bit 4 clear copies bits 1 and 0 to those pins. The two general outputs always follow control bits 3 and 2.
- R9: The change flag is high exactly while any delta bit is set.
- R10: A write with select = 1 does not change the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 selects the control byte, 1 selects the status byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while reg_rd is high, zero otherwise |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| rts_out | output | 1 | Request-to-send pin |
| dtr_out | output | 1 | Data-terminal-ready pin |
| out1_out | output | 1 | General output one |
| out2_out | output | 1 | General output two |
| status_chg | output | 1 | High while any delta bit is set |

## Verification
A status read that clears the delta bits can meet a newly synchronised line change at the same clock edge. The bench provokes this by clearing the deltas first and then toggling clear-to-send. It times a status read so that its closing edge is the third edge after the toggle. The read must return the pre-change byte with no delta bits set. The change flag must then be high, and a following read must show the new level with delta bit 0 set.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int REG_W  = 8;
    localparam int CTL_W  = 5;
    localparam int LINE_W = 4;

    typedef enum logic {
        SEL_CTL  = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    // Packed order equals the status nibble order (bit 3 .. bit 0).
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    // Packed order equals the control byte bit positions (bit 4 .. bit 0).
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    localparam line_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam ctl_t  CTL_RST  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};

    // Change record for one sampling step; the ring slot marks falling edges only.
    function automatic line_t change_of(line_t prev, line_t cur);
        line_t d;
        d.dcd = prev.dcd ^ cur.dcd;
        d.ri  = prev.ri & ~cur.ri;
        d.dsr = prev.dsr ^ cur.dsr;
        d.cts = prev.cts ^ cur.cts;
        return d;
    endfunction

    // Control outputs as seen by the status byte in loopback.
    function automatic line_t loop_view(ctl_t c);
        line_t v;
        v.dcd = c.out2;
        v.ri  = c.out1;
        v.dsr = c.dtr;
        v.cts = c.rts;
        return v;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int N = (STAGES < 1) ? 1 : STAGES;

    logic [W-1:0] stg [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= RST_VAL;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[N-1];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wval,
    output ctl_t             ctl_q,
    output logic             rts_pin,
    output logic             dtr_pin
);
    ctl_t wctl;
    assign wctl = ctl_t'(wval);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_RST;
            rts_pin <= 1'b0;
            dtr_pin <= 1'b0;
        end else if (wr) begin
            ctl_q <= wctl;
            if (!wctl.loop) begin
                rts_pin <= wctl.rts;
                dtr_pin <= wctl.dtr;
            end
        end
    end
endmodule

// File: rtl/mdm_stat.sv
module mdm_stat
    import mdm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t sync_lvl,
    input  logic  clr,
    output line_t lvl_q,
    output line_t delta_q
);
    line_t kept;
    line_t delta_d;

    always_comb begin
        kept    = clr ? line_t'('0) : delta_q;
        delta_d = kept | change_of(lvl_q, sync_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= LINE_RST;
            delta_q <= '0;
        end else begin
            lvl_q   <= sync_lvl;
            delta_q <= delta_d;
        end
    end
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             ri_in,
    input  logic             dcd_in,
    output logic             rts_out,
    output logic             dtr_out,
    output logic             out1_out,
    output logic             out2_out,
    output logic             status_chg
);
    localparam int PAD_W = REG_W - CTL_W;

    ctl_t  ctl_q;
    line_t pins, sync_lvl, lvl_q, delta_q;
    logic  ctl_wr, stat_clr;

    // Plain views for the bound checker.
    logic              loop_mode;
    logic [LINE_W-1:0] lvl_vec, sync_vec, delta_vec;

    assign pins     = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};
    assign ctl_wr   = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTL);
    assign stat_clr = reg_rd && (reg_sel_e'(reg_sel) == SEL_STAT) && !ctl_q.loop;

    mdm_sync #(
        .W      (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_RST)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (pins),
        .q  (sync_lvl)
    );

    mdm_ctrl i_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctl_wr),
        .wval   (wdata[CTL_W-1:0]),
        .ctl_q  (ctl_q),
        .rts_pin(rts_out),
        .dtr_pin(dtr_out)
    );

    mdm_stat i_stat (
        .clk     (clk),
        .rst     (rst),
        .sync_lvl(sync_lvl),
        .clr     (stat_clr),
        .lvl_q   (lvl_q),
        .delta_q (delta_q)
    );

    always_comb begin
        rdata = '0;
        if (reg_rd) begin
            if (reg_sel_e'(reg_sel) == SEL_CTL)
                rdata = {{PAD_W{1'b0}}, ctl_q};
            else if (ctl_q.loop)
                rdata = {loop_view(ctl_q), {LINE_W{1'b0}}};
            else
                rdata = {lvl_q, delta_q};
        end
    end

    assign out1_out   = ctl_q.out1;
    assign out2_out   = ctl_q.out2;
    assign status_chg = |delta_q;

    assign loop_mode = ctl_q.loop;
    assign lvl_vec   = lvl_q;
    assign sync_vec  = sync_lvl;
    assign delta_vec = delta_q;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       reg_sel,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       rts_out,
    input logic       dtr_out,
    input logic       status_chg,
    input logic       loop_mode,
    input logic [3:0] lvl_vec,
    input logic [3:0] sync_vec,
    input logic [3:0] delta_vec
);
    p_ctl_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_sel) |-> (rdata[7:5] == 3'b000));

    p_loop_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel && loop_mode) |-> (rdata[3:0] == 4'h0));

    p_pins_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel && wdata[4]) |=> ($stable(rts_out) && $stable(dtr_out)));

    p_ring_fall_only_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_vec[2]) |-> $fell(lvl_vec[2]));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel && !loop_mode && (sync_vec == lvl_vec)) |=> !status_chg);

    p_status_write_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && !reg_rd && (sync_vec == lvl_vec)) |=> $stable(delta_vec));
endmodule

bind mdm_ctl_stat mdm_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .rts_out   (rts_out),
    .dtr_out   (dtr_out),
    .status_chg(status_chg),
    .loop_mode (loop_mode),
    .lvl_vec   (lvl_vec),
    .sync_vec  (sync_vec),
    .delta_vec (delta_vec)
);

// File: tb/test_mdm_ctl_stat.sv
`timescale 1ns/1ps
module test_mdm_ctl_stat;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr, reg_rd, reg_sel;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [3:0] pin;    // {dcd, ri, dsr, cts}
    logic       rts_out, dtr_out, out1_out, out2_out, status_chg;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state
    logic [4:0] m_ctl;
    logic [3:0] m_lvl, m_dlt;
    logic       m_rts, m_dtr;

    always #2.5 clk = ~clk;

    mdm_ctl_stat i_mdm_ctl_stat (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata),
        .cts_in(pin[0]), .dsr_in(pin[1]), .ri_in(pin[2]), .dcd_in(pin[3]),
        .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out), .out2_out(out2_out),
        .status_chg(status_chg)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1], 4'h0};
        return {m_lvl, m_dlt};
    endfunction

    function automatic logic [3:0] chg(input logic [3:0] o, input logic [3:0] n);
        return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic reg_write(input logic sel, input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = sel; wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (!sel) begin
            m_ctl = v[4:0];
            if (!v[4]) begin m_rts = v[1]; m_dtr = v[0]; end
        end
    endtask

    task automatic reg_read(input logic sel, output logic [7:0] v);
        reg_rd = 1'b1; reg_sel = sel;
        #1 v = rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        if (sel && !m_ctl[4]) m_dlt = 4'h0;
    endtask

    task automatic drive_pins(input logic [3:0] p);
        pin = p;
        repeat (4) @(negedge clk);
        m_dlt = m_dlt | chg(m_lvl, p);
        m_lvl = p;
    endtask

    task automatic check_status(input string req);
        logic [7:0] e, v;
        e = exp_status();
        reg_read(1'b1, v);
        check(req, v, e);
    endtask

    task automatic check_ctl(input string req);
        logic [7:0] v;
        reg_read(1'b0, v);
        check(req, v, {3'b000, m_ctl});
        check({req, " pins"}, {4'h0, out2_out, out1_out, rts_out, dtr_out},
              {4'h0, m_ctl[3], m_ctl[2], m_rts, m_dtr});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        void'($urandom(32'd4242));
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_sel = 0; wdata = 0; pin = 4'b1011;
        m_ctl = 5'h08; m_lvl = 4'b1011; m_dlt = 4'h0; m_rts = 0; m_dtr = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check_ctl("R2 control");
        check_status("R2 status");
        check("R2 flag", {7'b0, status_chg}, 8'h00);

        // R1 bit map and padding
        reg_write(1'b0, 8'hE7);
        check_ctl("R1 write E7");

        // R5 ring rising sets nothing, falling sets bit 2
        drive_pins(4'b1111);
        check("R5 rise flag", {7'b0, status_chg}, 8'h00);
        check_status("R5 rise");
        drive_pins(4'b1011);
        check("R9 flag on fall", {7'b0, status_chg}, 8'h01);
        check_status("R5 fall");
        check_status("R6 cleared");

        // R3/R4 multi-line change, sticky across a second change back
        drive_pins(4'b0100);
        drive_pins(4'b0101);
        check_status("R4 sticky");

        // R10 status write ignored
        drive_pins(4'b1011);
        reg_write(1'b1, 8'h00);
        check_status("R10 after write");

        // R6 same-edge collision
        check_status("R6 pre");
        pin = 4'b1010;
        @(negedge clk); @(negedge clk);
        reg_rd = 1'b1; reg_sel = 1'b1;
        #1 check("R6 collide read", rdata, 8'hB0);
        @(negedge clk);
        reg_rd = 1'b0;
        m_lvl = 4'b1010; m_dlt = 4'b0001;
        check("R6 collide flag", {7'b0, status_chg}, 8'h01);
        check_status("R6 collide kept");

        // R7 loopback view, R8 pins held
        reg_write(1'b0, 8'h03);
        reg_write(1'b0, 8'h1C);
        check_ctl("R8 loop pins held");
        drive_pins(4'b0101);
        check_status("R7 loop view");
        check("R7 no clear flag", {7'b0, status_chg}, 8'h01);
        reg_write(1'b0, 8'h00);
        check_status("R7 deltas kept");

        // Random mix
        for (int i = 0; i < 200; i++) begin
            case ($urandom % 4)
                0: begin reg_write(1'b0, 8'($urandom)); check_ctl("R8 rand ctl"); end
                1: begin
                    drive_pins(4'($urandom));
                    check("R9 rand flag", {7'b0, status_chg}, {7'b0, |m_dlt});
                end
                2: check_status("R4 rand status");
                default: begin reg_write(1'b1, 8'($urandom)); check_status("R10 rand"); end
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule